// File: doc/BRIEF.md
# Binary Arithmetic Bin Decoder with Deferred Renormalization

This block turns a compressed bitstream back into binary decisions (bins), one bin per clock, without pipelining. Each request names its mode: context-coded or equiprobable (bypass). A context-coded request also carries a 6-bit probability state and the value of the more probable symbol (MPS). The block returns the decoded bin together with the successor state and MPS, which the caller writes back into its own context store.

The interval width (range) and the code value (offset) are both kept un-normalized in their registers. When the next request arrives, the block first shifts both registers left until range is at least 256. The least-probable-symbol width is looked up in the same cycle from four state-indexed sub-tables, one for each quarter of the normalized range. A bypass request adds one more left shift to the offset, which doubles it as part of that same shift. The caller supplies the stream through an 8-bit window, and the block reports how many bits of that window it takes for the current request.

Requests and results use valid/ready. A request is accepted on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low while `init` is high, and also while a result is held with `out_ready` low. A result stays on the outputs, unchanged, until it is taken. The caller must keep the request fields and `feed_bits` stable while `in_valid` is high and the request has not been accepted. After an accepted request, the caller advances its stream by the `need_bits` value it saw during that request.

Top module: `bin_arith_decoder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and `need_bits` is 0 for a context-coded request, because the reset range is 510.
- R2: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_bin`, `out_state` and `out_mps` hold their values.
- R3: An accepted request yields `out_valid` = 1 with its result on the next clock edge. Requests presented back to back are decoded at one bin per cycle.
- R4: The LPS width is floor((B[state]·M[q] + 4) / 8). Here q is bits [7:6] of the normalized range, M = {8, 11, 13, 15} for q = 0..3, and B is the 64-entry per-state base list in the shared package, which falls from 128 to 6.
- R5: For a context-coded request, let rMPS be the normalized range minus the LPS width. If the normalized offset is at least rMPS, the bin is the inverse of the MPS, rMPS is subtracted from the offset, and the range becomes the LPS width. Otherwise the bin equals the MPS and the range becomes rMPS.
- R6: On an MPS decision the state rises by one, up to a limit of 62. On an LPS decision the state follows the 64-entry LPS transition list in the package, and the MPS is inverted when the input state was 0.
- R7: A bypass request compares the offset, doubled with one new stream bit appended, against the full normalized range. The bin is 1 when the offset is at least the range, and the range is then subtracted. The range does not change, and `out_state` and `out_mps` equal the request's state and MPS.
- R8: `need_bits` equals the number of left shifts that bring the stored 9-bit range to 256 or more, plus 1 when `in_bypass` is 1. The new bits are taken MSB-first, starting at `feed_bits[7]`.
- R9: A cycle with `init` = 1 loads the offset from `init_bits` and the range with 510, and holds `in_ready` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init | input | 1 | Start a new stream, loading the offset and the range |
| init_bits | input | 9 | First nine stream bits, loaded into the offset on init |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted on this edge when valid |
| in_bypass | input | 1 | 1: bypass decode, 0: context-coded decode |
| in_state | input | 6 | Probability state of the context |
| in_mps | input | 1 | More probable symbol of the context |
| feed_bits | input | 8 | Next stream bits, oldest bit in bit 7 |
| need_bits | output | 3 | Number of `feed_bits` consumed by the presented request |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken on this edge when valid |
| out_bin | output | 1 | Decoded bin |
| out_state | output | 6 | Updated probability state |
| out_mps | output | 1 | Updated MPS |

## Verification
`need_bits` is combinational from the stored range and the presented mode. It is therefore due in the same cycle a request is driven, and it is sampled 1 ns after the drive, before the accepting edge. The bin, state and MPS pass through one register and are due on the edge that accepts the request. They are sampled at the following falling edge, against a reference model advanced exactly once per accepted request. During a stall, the bench samples the outputs two cycles later, to show that they still hold the previous result while the pending request waits.

// File: rtl/abd_pkg.sv
package abd_pkg;

  localparam int unsigned ST_W     = 6;
  localparam int unsigned ST_COUNT = 1 << ST_W;
  localparam int unsigned ST_SAT   = 62;
  localparam int unsigned QUARTERS = 4;

  // Per-state LPS width at the lowest range quarter.
  localparam logic [7:0] LPS_BASE [ST_COUNT] = '{
    8'd128, 8'd128, 8'd128, 8'd123, 8'd116, 8'd111, 8'd105, 8'd100,
    8'd95,  8'd90,  8'd85,  8'd81,  8'd77,  8'd73,  8'd69,  8'd66,
    8'd62,  8'd59,  8'd56,  8'd53,  8'd51,  8'd48,  8'd46,  8'd43,
    8'd41,  8'd39,  8'd37,  8'd35,  8'd33,  8'd32,  8'd30,  8'd29,
    8'd27,  8'd26,  8'd24,  8'd23,  8'd22,  8'd21,  8'd20,  8'd19,
    8'd18,  8'd17,  8'd16,  8'd15,  8'd14,  8'd14,  8'd13,  8'd12,
    8'd12,  8'd11,  8'd11,  8'd10,  8'd10,  8'd9,   8'd9,   8'd8,
    8'd8,   8'd7,   8'd7,   8'd7,   8'd6,   8'd6,   8'd6,   8'd6
  };

  // State reached after an LPS decision.
  localparam logic [ST_W-1:0] LPS_NEXT [ST_COUNT] = '{
    6'd0,  6'd0,  6'd1,  6'd2,  6'd2,  6'd4,  6'd4,  6'd5,
    6'd6,  6'd7,  6'd8,  6'd9,  6'd9,  6'd11, 6'd11, 6'd12,
    6'd13, 6'd13, 6'd15, 6'd15, 6'd16, 6'd16, 6'd18, 6'd18,
    6'd19, 6'd19, 6'd21, 6'd21, 6'd22, 6'd22, 6'd23, 6'd24,
    6'd24, 6'd25, 6'd26, 6'd26, 6'd27, 6'd27, 6'd28, 6'd29,
    6'd29, 6'd30, 6'd30, 6'd30, 6'd31, 6'd32, 6'd32, 6'd33,
    6'd33, 6'd33, 6'd34, 6'd34, 6'd35, 6'd35, 6'd35, 6'd36,
    6'd36, 6'd36, 6'd37, 6'd37, 6'd37, 6'd38, 6'd38, 6'd38
  };

  // Scale in eighths applied per range quarter.
  localparam logic [3:0] QUART_MUL [QUARTERS] = '{4'd8, 4'd11, 4'd13, 4'd15};

  typedef struct packed {
    logic            bin;
    logic [ST_W-1:0] state;
    logic            mps;
  } bin_result_t;

endpackage

// File: rtl/abd_renorm.sv
module abd_renorm #(
  parameter int unsigned RANGE_W = 9,
  parameter int unsigned FEED_W  = 8,
  parameter int unsigned SHIFT_W = 3
) (
  input  logic [RANGE_W-1:0] range_i,
  input  logic [RANGE_W-1:0] offset_i,
  input  logic [FEED_W-1:0]  feed_i,
  input  logic               bypass_i,
  output logic [RANGE_W-1:0] range_n_o,
  output logic [RANGE_W:0]   offset_n_o,
  output logic [SHIFT_W-1:0] shift_o
);

  logic [SHIFT_W-1:0] lead_zeros;
  logic               seen_one;
  logic [RANGE_W:0]   off_hi;
  logic [FEED_W-1:0]  fresh;

  // Leading-zero count of the stored range: the deferred shift.
  always_comb begin
    lead_zeros = '0;
    seen_one   = 1'b0;
    for (int i = RANGE_W - 1; i >= 0; i--) begin
      if (range_i[i]) begin
        seen_one = 1'b1;
      end else if (!seen_one) begin
        lead_zeros = lead_zeros + SHIFT_W'(1);
      end
    end
  end

  // Bypass doubles the offset by one extra step of the same shift.
  assign shift_o   = lead_zeros + SHIFT_W'(bypass_i);
  assign range_n_o = range_i << lead_zeros;

  always_comb begin
    off_hi     = (RANGE_W + 1)'({1'b0, offset_i}) << shift_o;
    fresh      = (feed_i >> (SHIFT_W'(FEED_W - 1) - shift_o)) >> 1;
    offset_n_o = off_hi | (RANGE_W + 1)'(fresh);
  end

endmodule

// File: rtl/abd_lps_lookup.sv
module abd_lps_lookup
  import abd_pkg::*;
#(
  parameter int unsigned RANGE_W = 9
) (
  input  logic [ST_W-1:0]    state_i,
  input  logic [1:0]         quarter_i,
  output logic [RANGE_W-1:0] rlps_o
);

  logic [RANGE_W-1:0] sub_val [QUARTERS];

  // One sub-table per range quarter, each addressed by state only.
  for (genvar g = 0; g < QUARTERS; g++) begin : g_sub
    logic [11:0] prod;
    always_comb prod = 12'(LPS_BASE[state_i]) * 12'(QUART_MUL[g]) + 12'd4;
    assign sub_val[g] = RANGE_W'(prod >> 3);
  end

  assign rlps_o = sub_val[quarter_i];

endmodule

// File: rtl/abd_decide.sv
module abd_decide
  import abd_pkg::*;
#(
  parameter int unsigned RANGE_W = 9
) (
  input  logic [RANGE_W-1:0] range_n_i,
  input  logic [RANGE_W:0]   offset_n_i,
  input  logic [RANGE_W-1:0] rlps_i,
  input  logic               bypass_i,
  input  logic [ST_W-1:0]    state_i,
  input  logic               mps_i,
  output bin_result_t        result_o,
  output logic [RANGE_W-1:0] range_nx_o,
  output logic [RANGE_W-1:0] offset_nx_o
);

  logic [RANGE_W-1:0] rmps;
  logic [RANGE_W-1:0] cmp_val;
  logic [RANGE_W:0]   off_diff;
  logic               take;

  assign rmps     = range_n_i - rlps_i;
  assign cmp_val  = bypass_i ? range_n_i : rmps;
  assign take     = offset_n_i >= {1'b0, cmp_val};
  assign off_diff = offset_n_i - {1'b0, cmp_val};

  always_comb begin
    offset_nx_o = RANGE_W'(take ? off_diff : offset_n_i);
    if (bypass_i) begin
      result_o.bin   = take;
      result_o.state = state_i;
      result_o.mps   = mps_i;
      range_nx_o     = range_n_i;
    end else if (take) begin
      result_o.bin   = !mps_i;
      result_o.state = LPS_NEXT[state_i];
      result_o.mps   = (state_i == '0) ? !mps_i : mps_i;
      range_nx_o     = rlps_i;
    end else begin
      result_o.bin   = mps_i;
      result_o.state = (state_i < ST_W'(ST_SAT)) ? state_i + ST_W'(1) : state_i;
      result_o.mps   = mps_i;
      range_nx_o     = rmps;
    end
  end

endmodule

// File: rtl/bin_arith_decoder.sv
module bin_arith_decoder
  import abd_pkg::*;
#(
  parameter int unsigned RANGE_W    = 9,
  parameter int unsigned FEED_W     = 8,
  parameter int unsigned INIT_RANGE = 510,
  localparam int unsigned SHIFT_W   = $clog2(FEED_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic [RANGE_W-1:0] init_bits,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_bypass,
  input  logic [ST_W-1:0]    in_state,
  input  logic               in_mps,
  input  logic [FEED_W-1:0]  feed_bits,
  output logic [SHIFT_W-1:0] need_bits,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_bin,
  output logic [ST_W-1:0]    out_state,
  output logic               out_mps
);

  logic [RANGE_W-1:0] range_q;
  logic [RANGE_W-1:0] offset_q;
  logic [RANGE_W-1:0] range_n;
  logic [RANGE_W:0]   offset_n;
  logic [RANGE_W-1:0] rlps;
  logic [RANGE_W-1:0] range_nx;
  logic [RANGE_W-1:0] offset_nx;
  bin_result_t        result_d;
  bin_result_t        result_q;
  logic               accept;

  assign in_ready = (!out_valid || out_ready) && !init;
  assign accept   = in_valid && in_ready;

  abd_renorm #(
    .RANGE_W (RANGE_W),
    .FEED_W  (FEED_W),
    .SHIFT_W (SHIFT_W)
  ) u_renorm (
    .range_i    (range_q),
    .offset_i   (offset_q),
    .feed_i     (feed_bits),
    .bypass_i   (in_bypass),
    .range_n_o  (range_n),
    .offset_n_o (offset_n),
    .shift_o    (need_bits)
  );

  abd_lps_lookup #(
    .RANGE_W (RANGE_W)
  ) u_lps (
    .state_i   (in_state),
    .quarter_i (range_n[RANGE_W-2 -: 2]),
    .rlps_o    (rlps)
  );

  abd_decide #(
    .RANGE_W (RANGE_W)
  ) u_decide (
    .range_n_i   (range_n),
    .offset_n_i  (offset_n),
    .rlps_i      (rlps),
    .bypass_i    (in_bypass),
    .state_i     (in_state),
    .mps_i       (in_mps),
    .result_o    (result_d),
    .range_nx_o  (range_nx),
    .offset_nx_o (offset_nx)
  );

  // Interval registers hold pre-renormalization values.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      range_q  <= RANGE_W'(INIT_RANGE);
      offset_q <= '0;
    end else if (init) begin
      range_q  <= RANGE_W'(INIT_RANGE);
      offset_q <= init_bits;
    end else if (accept) begin
      range_q  <= range_nx;
      offset_q <= offset_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result_q  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      result_q  <= result_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_bin   = result_q.bin;
  assign out_state = result_q.state;
  assign out_mps   = result_q.mps;

endmodule

// File: rtl/abd_decoder_chk.sv
module abd_decoder_chk
  import abd_pkg::*;
#(
  parameter int unsigned SHIFT_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               init,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_bypass,
  input logic [ST_W-1:0]    in_state,
  input logic               in_mps,
  input logic [SHIFT_W-1:0] need_bits,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_bin,
  input logic [ST_W-1:0]    out_state,
  input logic               out_mps
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bin) && $stable(out_state) && $stable(out_mps));

  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  p_mps_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_bypass && (in_state < ST_W'(ST_SAT))
    |=> (out_bin != $past(in_mps)) || (out_state == $past(in_state) + ST_W'(1)));

  p_ctx_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_bypass
    |=> out_state == $past(in_state) && out_mps == $past(in_mps));

  p_need_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_bypass |-> need_bits <= SHIFT_W'(6));

  p_init_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init |-> !in_ready);

endmodule

bind bin_arith_decoder abd_decoder_chk #(.SHIFT_W(SHIFT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .init      (init),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_bypass (in_bypass),
  .in_state  (in_state),
  .in_mps    (in_mps),
  .need_bits (need_bits),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bin   (out_bin),
  .out_state (out_state),
  .out_mps   (out_mps)
);

// File: tb/bin_arith_decoder_bench.sv
module bin_arith_decoder_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, init, in_valid, in_ready, in_bypass, in_mps;
  logic       out_valid, out_ready, out_bin, out_mps;
  logic [8:0] init_bits;
  logic [5:0] in_state, out_state;
  logic [7:0] feed_bits;
  logic [2:0] need_bits;

  bin_arith_decoder u_bin_arith_decoder (
    .clk(clk), .rst_n(rst_n), .init(init), .init_bits(init_bits),
    .in_valid(in_valid), .in_ready(in_ready), .in_bypass(in_bypass),
    .in_state(in_state), .in_mps(in_mps), .feed_bits(feed_bits),
    .need_bits(need_bits), .out_valid(out_valid), .out_ready(out_ready),
    .out_bin(out_bin), .out_state(out_state), .out_mps(out_mps)
  );

  localparam int SBASE [64] = '{128,128,128,123,116,111,105,100,95,90,85,81,77,73,69,66,
    62,59,56,53,51,48,46,43,41,39,37,35,33,32,30,29,27,26,24,23,22,21,20,19,
    18,17,16,15,14,14,13,12,12,11,11,10,10,9,9,8,8,7,7,7,6,6,6,6};
  localparam int SNEXT [64] = '{0,0,1,2,2,4,4,5,6,7,8,9,9,11,11,12,13,13,15,15,16,16,18,18,
    19,19,21,21,22,22,23,24,24,25,26,26,27,27,28,29,29,30,30,30,31,32,32,33,
    33,33,34,34,35,35,35,36,36,36,37,37,37,38,38,38};
  localparam int QMUL [4] = '{8, 11, 13, 15};

  int n_checks = 0;
  int n_fail   = 0;
  bit stream [4096];
  int ptr      = 0;
  int m_range  = 510;
  int m_offset = 0;
  int e_bin, e_state, e_mps;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int need_of(input int r, input bit byp);
    int s = 0;
    while (r < 256) begin
      r = r * 2;
      s++;
    end
    return s + int'(byp);
  endfunction

  function automatic logic [7:0] feed_at(input int p);
    logic [7:0] f;
    for (int i = 0; i < 8; i++) f[7-i] = stream[(p + i) % 4096];
    return f;
  endfunction

  // Reference decode, advanced once per accepted request.
  task automatic model_step(input bit byp, input int st, input bit mp);
    int r  = m_range;
    int o  = m_offset;
    int sh = need_of(m_range, 1'b0);
    int n  = need_of(m_range, byp);
    int lps, rm;
    for (int i = 0; i < sh; i++) r = r * 2;
    for (int i = 0; i < n; i++) o = o * 2 + int'(stream[(ptr + i) % 4096]);
    ptr = ptr + n;
    if (byp) begin
      e_bin = (o >= r) ? 1 : 0;
      if (o >= r) o = o - r;
      e_state = st;
      e_mps   = mp;
      m_range = r;
    end else begin
      lps = (SBASE[st] * QMUL[(r >> 6) & 3] + 4) / 8;
      rm  = r - lps;
      if (o >= rm) begin
        e_bin   = mp ? 0 : 1;
        o       = o - rm;
        m_range = lps;
        e_state = SNEXT[st];
        e_mps   = (st == 0) ? (mp ? 0 : 1) : int'(mp);
      end else begin
        e_bin   = mp;
        m_range = rm;
        e_state = (st < 62) ? st + 1 : st;
        e_mps   = mp;
      end
    end
    m_offset = o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic do_init(input int val);
    init      = 1'b1;
    init_bits = 9'(val);
    in_bypass = 1'b0;
    #1;
    chk("R9 in_ready during init", in_ready, 0);
    @(posedge clk);
    @(negedge clk);
    #1;
    init     = 1'b0;
    m_range  = 510;
    m_offset = val;
    #1;
    chk("R9 need_bits after init", need_bits, 0);
  endtask

  task automatic run_one(input bit byp, input int st, input bit mp);
    in_valid  = 1'b1;
    in_bypass = byp;
    in_state  = 6'(st);
    in_mps    = mp;
    feed_bits = feed_at(ptr);
    #1;
    chk("R8 need_bits", need_bits, need_of(m_range, byp));
    model_step(byp, st, mp);
    @(posedge clk);
    @(negedge clk);
    #1;
    in_valid = 1'b0;
    chk("R3 out_valid", out_valid, 1);
    chk(byp ? "R7 bin" : "R5 bin", out_bin, e_bin);
    chk(byp ? "R7 state" : "R6 state", out_state, e_state);
    chk(byp ? "R7 mps" : "R6 mps", out_mps, e_mps);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int sa, sb, sc, sd, v;
    void'($urandom(32'd7391));
    for (int i = 0; i < 4096; i++) stream[i] = 1'($urandom % 2);
    rst_n = 1'b0; init = 1'b0; init_bits = '0; in_valid = 1'b0; in_bypass = 1'b0;
    in_state = '0; in_mps = 1'b0; feed_bits = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 in_ready after reset", in_ready, 1);
    chk("R1 need_bits after reset", need_bits, 0);

    // LPS at state 0 flips the MPS.
    do_init(509);
    run_one(1'b0, 0, 1'b0);
    chk("R6 flip bin", out_bin, 1);
    chk("R6 flip state", out_state, 0);
    chk("R6 flip mps", out_mps, 1);
    chk("R4 need after width 240", need_bits, 1);

    // Top quarter, state 20: LPS width 96, two shifts pending.
    do_init(509);
    run_one(1'b0, 20, 1'b0);
    chk("R4 need after width 96", need_bits, 2);

    // MPS at the state limit stays at 62.
    do_init(0);
    run_one(1'b0, 62, 1'b1);
    chk("R6 saturate state", out_state, 62);
    chk("R5 mps bin", out_bin, 1);

    // Bypass: doubled offset against full range.
    do_init(509);
    run_one(1'b1, 10, 1'b1);
    chk("R7 bypass bin", out_bin, 1);
    chk("R7 bypass state", out_state, 10);

    // Back-pressure.
    idle(1);
    out_ready = 1'b0;
    run_one(1'b0, 5, 1'b1);
    sa = e_bin; sb = e_state; sc = e_mps;
    in_valid  = 1'b1;
    in_bypass = 1'b0;
    in_state  = 6'd30;
    in_mps    = 1'b0;
    feed_bits = feed_at(ptr);
    #1;
    chk("R2 in_ready stalled", in_ready, 0);
    sd = need_of(m_range, 1'b0);
    idle(2);
    chk("R2 held valid", out_valid, 1);
    chk("R2 held bin", out_bin, sa);
    chk("R2 held state", out_state, sb);
    chk("R2 held mps", out_mps, sc);
    chk("R2 still stalled", in_ready, 0);
    out_ready = 1'b1;
    #1;
    chk("R2 ready after release", in_ready, 1);
    chk("R8 need after stall", need_bits, sd);
    model_step(1'b0, 30, 1'b0);
    @(posedge clk);
    @(negedge clk);
    #1;
    in_valid = 1'b0;
    chk("R3 valid after stall", out_valid, 1);
    chk("R5 bin after stall", out_bin, e_bin);
    chk("R6 state after stall", out_state, e_state);

    // Constrained random run.
    for (int k = 0; k < 1200; k++) begin
      if (k % 200 == 0) begin
        v = 0;
        for (int i = 0; i < 9; i++) v = v * 2 + int'(stream[(ptr + i) % 4096]);
        ptr = ptr + 9;
        do_init(v % 510);
      end
      run_one(($urandom % 4) == 0, int'($urandom % 63), 1'($urandom % 2));
      if (($urandom % 8) == 0) idle(1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule